// File: doc/BRIEF.md
# Configurable Parallel Prefix Adder

This block adds two unsigned binary operands of a parameterised width together with a one-bit carry-in. It returns the sum modulo two to the width and a carry-out. It is purely combinational. A datapath instantiates it wherever a wide add sits on a critical path, and picks the carry network that suits its timing and area budget through one parameter.

The block is built in three parts. The first is a per-bit stage that forms generate (a AND b) and propagate (a XOR b). The second is a prefix network of combine cells that yields the group generate from each bit down to the carry-in. The carry-in counts as the generate of an extra position below bit 0. The third part forms each sum bit as the bit's propagate XOR the carry entering it.

A full combine cell merges a higher pair (gh, ph) with a lower pair (gl, pl) into G = gh | (ph & gl) and P = ph & pl. A reduced cell produces only G, and is used where the result already reaches the carry-in. Four network shapes are offered:
- a minimum-depth tree in which each node feeds at most two others;
- an up-sweep/down-sweep tree with the fewest cells and the greatest depth;
- a minimum-depth tree with high fan-out;
- a sparse tree that resolves only the carry into every fourth bit and completes each 4-bit group with a short ripple.

Top module: `ppa_adder`

## Requirements
- R1: For every topology (TOPO encoding 0 = fan-out-two minimum depth, 1 = fewest cells, 2 = high fan-out minimum depth, 3 = sparse with 4-bit ripple groups) and every operand pair, sum_o equals (a_i + b_i + cin_i) mod 2^WIDTH.
- R2: cout_o equals bit WIDTH of the full-precision value a_i + b_i + cin_i; for example, both operands equal to 2^(WIDTH-1) with cin_i = 0 give sum_o = 0 and cout_o = 1.
- R3: When every propagate bit is set (a_i XOR b_i all ones), the carry-in passes through the whole width: with cin_i = 1 the sum is zero and cout_o is 1, and with cin_i = 0 the sum is all ones and cout_o is 0.
- R4: An all-ones operand plus an operand of value one, with cin_i = 0, gives sum_o = 0 and cout_o = 1, in either operand order.
- R5: Alternating bit patterns (0xAA.. and 0x55.. repeated to the width, in any pairing with themselves or each other, with or without carry-in) add correctly.
- R6: The carry-in has weight one at bit 0: zero operands with cin_i = 1 give sum_o = 1 and cout_o = 0, and zero operands with cin_i = 0 give zero outputs.
- R7: The carry entering each bit i equals g[i-1] | (p[i-1] & carry into bit i-1), with the carry into bit 0 being cin_i. Every sum bit equals a_i[i] XOR b_i[i] XOR that carry, including carries that cross a 4-bit group boundary.
- R8: All four topologies produce bit-identical sum_o and cout_o for the same inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum modulo 2^WIDTH |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
The bench builds every topology at WIDTH 8, 16 and 32, twelve instances in all, and drives the same inputs into all four topologies of a width at once. At WIDTH 8 the whole space of operands and carry-in is small enough to sweep exhaustively. Every tree shape and every sparse group boundary is therefore reached with every input pattern. At WIDTH 16 and 32 the bench drives 100000 random vectors per width. It adds the directed cases: full-width propagate, all-ones plus one, alternating patterns, and a carry crossing each 4-bit group.

// File: rtl/ppa_pkg.sv
package ppa_pkg;

  typedef enum logic [1:0] {
    TOPO_KS     = 2'd0,
    TOPO_BK     = 2'd1,
    TOPO_LF     = 2'd2,
    TOPO_SPARSE = 2'd3
  } topo_e;

  // Number of combine levels the chosen network needs.
  function automatic int stage_count(topo_e t, int n);
    int lv;
    lv = $clog2(n);
    if (t == TOPO_BK) return 2 * lv - 1;
    return lv;
  endfunction

  // Index of the lower node that node i combines with at stage s,
  // or -1 when node i passes through unchanged.
  function automatic int partner(topo_e t, int n, int s, int i);
    int lv;
    int d;
    int lp;
    lv = $clog2(n);
    d  = 1 << (s - 1);
    case (t)
      TOPO_KS: begin
        if (i >= d) return i - d;
        return -1;
      end
      TOPO_LF: begin
        if (((i >> (s - 1)) & 1) == 1) return ((i >> (s - 1)) << (s - 1)) - 1;
        return -1;
      end
      TOPO_BK: begin
        if (s <= lv) begin
          if (((i + 1) % (2 * d)) == 0) return i - d;
          return -1;
        end
        lp = 2 * lv - s;
        d  = 1 << (lp - 1);
        if ((((i + 1) % (2 * d)) == d) && (i >= 2 * d)) return i - d;
        return -1;
      end
      default: begin
        if (s == 1) begin
          if ((i % 2) == 1) return i - 1;
          return -1;
        end
        if (s == 2) begin
          if ((i % 4) == 3) return i - 2;
          return -1;
        end
        if (((i % 4) == 3) && (i >= d)) return i - d;
        return -1;
      end
    endcase
  endfunction

  // Lowest bit position covered by node i after stage s.
  function automatic int low_index(topo_e t, int n, int s, int i);
    int idx;
    int j;
    idx = i;
    for (int k = s; k >= 1; k--) begin
      j = partner(t, n, k, idx);
      if (j >= 0) idx = j;
    end
    return idx;
  endfunction

  // Full combine cell: {G, P}.
  function automatic logic [1:0] black_gp(logic gh, logic ph, logic gl, logic pl);
    return {gh | (ph & gl), ph & pl};
  endfunction

  // Reduced combine cell: G only.
  function automatic logic gray_g(logic gh, logic ph, logic gl);
    return gh | (ph & gl);
  endfunction

endpackage

// File: rtl/ppa_gp_stage.sv
module ppa_gp_stage #(
  parameter int N = 16
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         cin_i,
  output logic [N-1:0] gen_o,
  output logic [N-1:0] prop_o,
  output logic [N-1:0] seed_o
);
  import ppa_pkg::*;

  assign gen_o  = a_i & b_i;
  assign prop_o = a_i ^ b_i;

  // Bit 0 absorbs the carry-in, which sits at position -1.
  assign seed_o[0] = gray_g(gen_o[0], prop_o[0], cin_i);
  if (N > 1) begin : g_upper
    assign seed_o[N-1:1] = gen_o[N-1:1];
  end

endmodule

// File: rtl/ppa_prefix_net.sv
module ppa_prefix_net
  import ppa_pkg::*;
#(
  parameter int    N    = 16,
  parameter topo_e TOPO = TOPO_KS
) (
  input  logic [N-1:0] seed_i,
  input  logic [N-1:0] prop_i,
  output logic [N-1:0] grp_g_o
);

  localparam int NS = stage_count(TOPO, N);

  logic [NS:0][N-1:0] g_st;
  logic [NS:0][N-1:0] p_st;

  assign g_st[0] = seed_i;
  assign p_st[0] = prop_i;

  for (genvar s = 1; s <= NS; s++) begin : g_stage
    for (genvar i = 0; i < N; i++) begin : g_node
      localparam int J = partner(TOPO, N, s, i);
      if (J < 0) begin : g_pass
        assign g_st[s][i] = g_st[s-1][i];
        assign p_st[s][i] = p_st[s-1][i];
      end else if (low_index(TOPO, N, s - 1, J) == 0) begin : g_gray
        // Result reaches the carry-in: only the generate is needed.
        assign g_st[s][i] = gray_g(g_st[s-1][i], p_st[s-1][i], g_st[s-1][J]);
        assign p_st[s][i] = 1'b0;
      end else begin : g_black
        assign {g_st[s][i], p_st[s][i]} =
          black_gp(g_st[s-1][i], p_st[s-1][i], g_st[s-1][J], p_st[s-1][J]);
      end
    end
  end

  assign grp_g_o = g_st[NS];

endmodule

// File: rtl/ppa_carry_stage.sv
module ppa_carry_stage
  import ppa_pkg::*;
#(
  parameter int    N    = 16,
  parameter topo_e TOPO = TOPO_KS
) (
  input  logic [N-1:0] grp_g_i,
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin_i,
  output logic [N:0]   carry_o
);

  localparam int GW = 4;
  localparam int NG = N / GW;

  if (TOPO == TOPO_SPARSE) begin : g_sparse
    for (genvar k = 0; k < NG; k++) begin : g_grp
      logic [GW-1:0] rc;
      if (k == 0) begin : g_first
        assign rc[0] = cin_i;
      end else begin : g_rest
        assign rc[0] = grp_g_i[GW*k-1];
      end
      for (genvar j = 0; j < GW - 1; j++) begin : g_rip
        assign rc[j+1] = gray_g(gen_i[GW*k+j], prop_i[GW*k+j], rc[j]);
      end
      assign carry_o[GW*k +: GW] = rc;
    end
    assign carry_o[N] = grp_g_i[N-1];
  end else begin : g_dense
    assign carry_o[0]     = cin_i;
    assign carry_o[N:1]   = grp_g_i;
  end

endmodule

// File: rtl/ppa_sum_stage.sv
module ppa_sum_stage #(
  parameter int N = 16
) (
  input  logic [N-1:0] prop_i,
  input  logic [N:0]   carry_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o
);

  assign sum_o  = prop_i ^ carry_i[N-1:0];
  assign cout_o = carry_i[N];

endmodule

// File: rtl/ppa_adder.sv
module ppa_adder
  import ppa_pkg::*;
#(
  parameter int    WIDTH = 16,
  parameter topo_e TOPO  = TOPO_KS
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  logic [WIDTH-1:0] gen_w;
  logic [WIDTH-1:0] prop_w;
  logic [WIDTH-1:0] seed_w;
  logic [WIDTH-1:0] grp_g_w;
  logic [WIDTH:0]   carry_w;

  ppa_gp_stage #(.N(WIDTH)) u_gp (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .gen_o  (gen_w),
    .prop_o (prop_w),
    .seed_o (seed_w)
  );

  ppa_prefix_net #(.N(WIDTH), .TOPO(TOPO)) u_net (
    .seed_i  (seed_w),
    .prop_i  (prop_w),
    .grp_g_o (grp_g_w)
  );

  ppa_carry_stage #(.N(WIDTH), .TOPO(TOPO)) u_carry (
    .grp_g_i (grp_g_w),
    .gen_i   (gen_w),
    .prop_i  (prop_w),
    .cin_i   (cin_i),
    .carry_o (carry_w)
  );

  ppa_sum_stage #(.N(WIDTH)) u_sum (
    .prop_i  (prop_w),
    .carry_i (carry_w),
    .sum_o   (sum_o),
    .cout_o  (cout_o)
  );

endmodule

// File: rtl/ppa_adder_chk.sv
module ppa_adder_chk #(
  parameter int N = 16
) (
  input logic [N-1:0] a_i,
  input logic [N-1:0] b_i,
  input logic         cin_i,
  input logic [N-1:0] sum_i,
  input logic         cout_i,
  input logic [N:0]   carry_i,
  input logic [N-1:0] gen_i,
  input logic [N-1:0] prop_i
);

  logic [N:0] full_w;
  assign full_w = {1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, cin_i};

  always_comb begin
    p_sum_r1: assert (sum_i == full_w[N-1:0])
      else $error("sum mismatch against arithmetic value");
    p_cout_r2: assert (cout_i == full_w[N])
      else $error("carry-out mismatch against arithmetic value");
    p_carry_in_r6: assert (carry_i[0] == cin_i)
      else $error("carry into bit 0 differs from carry-in");
    p_allprop_r3: assert (!(&prop_i) || ((cout_i == cin_i) && (sum_i == {N{~cin_i}})))
      else $error("full propagate did not pass the carry-in through");
    for (int i = 0; i < N; i++) begin
      p_ripple_r7: assert (carry_i[i+1] == (gen_i[i] | (prop_i[i] & carry_i[i])))
        else $error("network carry into bit %0d breaks the recurrence", i + 1);
    end
  end

endmodule

bind ppa_adder ppa_adder_chk #(.N(WIDTH)) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .cin_i   (cin_i),
  .sum_i   (sum_o),
  .cout_i  (cout_o),
  .carry_i (carry_w),
  .gen_i   (gen_w),
  .prop_i  (prop_w)
);

// File: tb/sim_ppa_adder.sv
module sim_ppa_adder;
  import ppa_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0]  a8,  b8;  logic ci8;
  logic [15:0] a16, b16; logic ci16;
  logic [31:0] a32, b32; logic ci32;
  logic [7:0]  s8  [4]; logic co8  [4];
  logic [15:0] s16 [4]; logic co16 [4];
  logic [31:0] s32 [4]; logic co32 [4];

  for (genvar t = 0; t < 4; t++) begin : g8
    ppa_adder #(.WIDTH(8), .TOPO(topo_e'(t))) u0 (
      .a_i(a8), .b_i(b8), .cin_i(ci8), .sum_o(s8[t]), .cout_o(co8[t]));
  end
  for (genvar t = 0; t < 4; t++) begin : g16
    ppa_adder #(.WIDTH(16), .TOPO(topo_e'(t))) u0 (
      .a_i(a16), .b_i(b16), .cin_i(ci16), .sum_o(s16[t]), .cout_o(co16[t]));
  end
  for (genvar t = 0; t < 4; t++) begin : g32
    ppa_adder #(.WIDTH(32), .TOPO(topo_e'(t))) u0 (
      .a_i(a32), .b_i(b32), .cin_i(ci32), .sum_o(s32[t]), .cout_o(co32[t]));
  end

  task automatic chk(input string req, input int w, input int t, input logic [31:0] x,
                     input logic [31:0] y, input logic c, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: width=%0d topo=%0d a=%h b=%h cin=%0d actual=%h expected=%h",
               req, w, t, x, y, c, act, exp);
    end
  endtask

  task automatic apply(input int w, input logic [31:0] xi, input logic [31:0] yi,
                       input logic c, input string req, input bit deep);
    logic [31:0] m, x, y, s, s0, rip;
    logic [32:0] full;
    logic        co, rc;
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    x = xi & m;
    y = yi & m;
    case (w)
      8:       begin a8  = x[7:0];  b8  = y[7:0];  ci8  = c; end
      16:      begin a16 = x[15:0]; b16 = y[15:0]; ci16 = c; end
      default: begin a32 = x;       b32 = y;       ci32 = c; end
    endcase
    #1;
    full = {1'b0, x} + {1'b0, y} + {32'd0, c};
    // Bit-serial restatement using a majority carry.
    rc  = c;
    rip = '0;
    for (int i = 0; i < w; i++) begin
      rip[i] = x[i] ^ y[i] ^ rc;
      rc     = (x[i] & y[i]) | (rc & (x[i] | y[i]));
    end
    s0 = '0;
    for (int t = 0; t < 4; t++) begin
      case (w)
        8:       begin s = {24'd0, s8[t]};  co = co8[t];  end
        16:      begin s = {16'd0, s16[t]}; co = co16[t]; end
        default: begin s = s32[t];          co = co32[t]; end
      endcase
      if (t == 0) s0 = s;
      chk(req, w, t, x, y, c, s, full[31:0] & m);
      chk("R2", w, t, x, y, c, {31'd0, co}, {31'd0, full[w]});
      if (deep) begin
        chk("R7", w, t, x, y, c, s, rip);
        chk("R8", w, t, x, y, c, s, s0);
      end
    end
  endtask

  task automatic edges(input int w);
    logic [31:0] m, msb;
    m   = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    msb = 32'd1 << (w - 1);
    apply(w, 32'd0, 32'd0, 1'b0, "R6", 1);
    apply(w, 32'd0, 32'd0, 1'b1, "R6", 1);
    apply(w, m, 32'd0, 1'b1, "R3", 1);
    apply(w, m, 32'd0, 1'b0, "R3", 1);
    apply(w, 32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R3", 1);
    apply(w, m, 32'd1, 1'b0, "R4", 1);
    apply(w, 32'd1, m, 1'b0, "R4", 1);
    apply(w, 32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "R5", 1);
    apply(w, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0, "R5", 1);
    apply(w, 32'h5555_5555, 32'h5555_5555, 1'b1, "R5", 1);
    apply(w, 32'h5555_5555, 32'hAAAA_AAAA, 1'b1, "R5", 1);
    apply(w, msb, msb, 1'b0, "R2", 1);
    apply(w, m, m, 1'b1, "R2", 1);
    for (int k = 0; k < w / 4; k++) begin
      apply(w, 32'hF << (4 * k), 32'h1 << (4 * k), 1'b0, "R7", 1);
      apply(w, 32'h7 << (4 * k), 32'h8 << (4 * k), 1'b1, "R7", 1);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    a8 = '0; b8 = '0; ci8 = 1'b0;
    a16 = '0; b16 = '0; ci16 = 1'b0;
    a32 = '0; b32 = '0; ci32 = 1'b0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    #3;
    // Initial state with zero inputs: all outputs zero (R6).
    apply(8, 32'd0, 32'd0, 1'b0, "R6", 1);

    edges(8);
    edges(16);
    edges(32);

    // Exhaustive 8-bit sweep, every topology (R1).
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++)
        for (int c = 0; c < 2; c++)
          apply(8, 32'(x), 32'(y), c[0], "R1", 0);

    for (int n = 0; n < 100000; n++)
      apply(16, $urandom(), $urandom(), 1'($urandom() & 1), "R1", 0);
    for (int n = 0; n < 100000; n++)
      apply(32, $urandom(), $urandom(), 1'($urandom() & 1), "R1", 0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1: watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule